// File: doc/BRIEF.md
# Memory Read Completion Splitter

This block serves the completer end of a PCIe link, for example inside a root port model. It takes one 32-bit Memory Read request (DWORD start address, length in DWORDs, tag and requester ID) and answers it with a run of Completion-with-Data packets. Each completion carries at most the payload allowed by the Max Payload Size setting. The payload words come from a plain synchronous memory port with one cycle of read latency.

Completions leave on a single valid/ready stream. Each completion starts with one header beat, marked by `outSop`, whose fields appear on the `cpl*` sideband outputs. The data beats follow, one DWORD each, and the last one is marked by `outEop`. Every completion repeats the request's tag and requester ID, carries the completer ID that was set up at accept time, and reports how many bytes are still owed, the current completion included. The block holds one request at a time.

Top module: `cpl_splitter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `outValid` is 0 and `reqReady` is 1.
- R2: A request length of 0 is taken as 1024 DWORDs (4096 bytes). Any other length L is taken as L DWORDs.
- R3: `mpsSel` codes 0, 1 and 2 allow 32, 64 and 128 payload DWORDs per completion. Codes 3 to 7 allow 32. Each completion is full size except the last one, which carries the remainder. A 4096-byte read therefore gives 32 completions with code 0, 16 with code 1 and 8 with code 2.
- R4: Every header beat carries the request's tag on `cplTag`, its requester ID on `cplReqId`, and the value of `cplId` sampled at accept on `cplCplId`.
- R5: On each header beat, `cplByteCnt` equals 4 times the number of DWORDs not yet sent, the current completion included, kept to 12 bits. A full 4096 bytes therefore reads as 0.
- R6: On each header beat, `cplLowAddr` equals the low 7 bits of the byte address of that completion's first payload byte. This is the completion's first DWORD address, bits [4:0], followed by two zero bits.
- R7: `reqAddr` is a DWORD address (byte address divided by 4). The payload DWORDs are the memory words at consecutive DWORD addresses starting at `reqAddr`, wrapping modulo 2^ADDR_W. `memRdData` is the word at the `memAddr` presented, while `memRdEn` was high, one cycle earlier.
- R8: While `outValid` is 1 and `outReady` is 0, `outSop`, `outData`, `cplLen` and `cplByteCnt` hold their values.
- R9: `reqReady` is low from the cycle after a request is accepted until the final data beat of that request has been taken. A request offered while `reqReady` is low is ignored.
- R10: Changing `mpsSel` or `cplId` after a request has been accepted has no effect on that request's completions.
- R11: Each completion is one header beat (`outSop`=1), followed by exactly `cplLen` data beats (`outSop`=0), the last of which has `outEop`=1. `outValid` stays high from accept until the final beat.
- R12: With `outReady` held high, one payload DWORD is sent per cycle with no gaps between the beats of a completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request can be taken |
| reqAddr | input | ADDR_W | Start DWORD address |
| reqLen | input | LEN_W | Length in DWORDs, 0 means 1024 |
| reqTag | input | TAG_W | Request tag |
| reqRid | input | ID_W | Requester ID |
| mpsSel | input | 3 | Max payload code |
| cplId | input | ID_W | Completer bus/device/function |
| memRdEn | output | 1 | Memory read enable |
| memAddr | output | ADDR_W | Memory DWORD address |
| memRdData | input | DATA_W | Memory read data, one cycle latency |
| outValid | output | 1 | Stream beat valid |
| outReady | input | 1 | Stream beat taken |
| outSop | output | 1 | Header beat |
| outEop | output | 1 | Last data beat of a completion |
| outData | output | DATA_W | Payload DWORD, zero on header beat |
| cplLen | output | LEN_W | Completion payload length in DWORDs |
| cplByteCnt | output | LEN_W+2 | Remaining byte count |
| cplLowAddr | output | 7 | Lower address |
| cplTag | output | TAG_W | Completion tag |
| cplReqId | output | ID_W | Requester ID |
| cplCplId | output | ID_W | Completer ID |

## Verification
Some behaviours are checked on every cycle. These are the header fields held steady under backpressure, the length limit taken from the payload code latched at accept, the repeated tag, a byte count that matches an independently kept remaining-DWORD counter, end-of-packet falling exactly on the announced length, and the request port staying closed while DWORDs are still owed. Other behaviours need the bench scenarios. These are the payload word at each address, the lower address, the completion counts for maximum-length reads under each payload code, the fallback for reserved codes, address wraparound, and the ignored second request and mid-transfer setting changes.

// File: rtl/cpl_splitter_pkg.sv
package cpl_splitter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2
  } splitState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic hdrFire;
    logic beatFire;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic lastBeat;
    logic lastCpl;
  } dpStat_t;

  // payload limit in DWORDs for a 3-bit payload code
  function automatic logic [7:0] mpsDwords(input logic [2:0] sel);
    case (sel)
      3'd0:    return 8'd32;
      3'd1:    return 8'd64;
      3'd2:    return 8'd128;
      default: return 8'd32;
    endcase
  endfunction

endpackage

// File: rtl/cpl_splitter_ctrl.sv
module cpl_splitter_ctrl
  import cpl_splitter_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    outReady,
  input  dpStat_t stat,
  output logic    reqReady,
  output logic    outValid,
  output logic    outSop,
  output logic    outEop,
  output logic    memRdEn,
  output dpCtrl_t ctrl
);

  splitState_e state;
  splitState_e stateNext;

  always_comb begin
    reqReady      = (state == ST_IDLE);
    outValid      = (state != ST_IDLE);
    outSop        = (state == ST_HDR);
    outEop        = (state == ST_DATA) && stat.lastBeat;
    memRdEn       = (state != ST_IDLE);
    ctrl.load     = (state == ST_IDLE) && reqValid;
    ctrl.hdrFire  = (state == ST_HDR) && outReady;
    ctrl.beatFire = (state == ST_DATA) && outReady;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) stateNext = ST_HDR;
      ST_HDR:  if (outReady) stateNext = ST_DATA;
      ST_DATA: begin
        if (outReady && stat.lastBeat) begin
          stateNext = stat.lastCpl ? ST_IDLE : ST_HDR;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/cpl_splitter_dp.sv
module cpl_splitter_dp
  import cpl_splitter_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 10,
  parameter int TAG_W  = 8,
  parameter int ID_W   = 16,
  localparam int REM_W = LEN_W + 1,
  localparam int BC_W  = LEN_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [ID_W-1:0]   reqRid,
  input  logic [2:0]        mpsSel,
  input  logic [ID_W-1:0]   cplId,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LEN_W-1:0]  cplLen,
  output logic [BC_W-1:0]   cplByteCnt,
  output logic [6:0]        cplLowAddr,
  output logic [TAG_W-1:0]  cplTag,
  output logic [ID_W-1:0]   cplReqId,
  output logic [ID_W-1:0]   cplCplId
);

  logic [ADDR_W-1:0] ptr;
  logic [REM_W-1:0]  remDw;
  logic [REM_W-1:0]  beatsLeft;
  logic [2:0]        mpsQ;
  logic [TAG_W-1:0]  tagQ;
  logic [ID_W-1:0]   ridQ;
  logic [ID_W-1:0]   cidQ;
  logic [REM_W-1:0]  mpsW;
  logic [REM_W-1:0]  chunk;
  logic [REM_W-1:0]  loadLen;

  always_comb begin
    mpsW    = REM_W'(mpsDwords(mpsQ));
    chunk   = (remDw < mpsW) ? remDw : mpsW;
    loadLen = (reqLen == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, reqLen};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr       <= '0;
      remDw     <= '0;
      beatsLeft <= '0;
      mpsQ      <= '0;
      tagQ      <= '0;
      ridQ      <= '0;
      cidQ      <= '0;
    end else begin
      if (ctrl.load) begin
        ptr   <= reqAddr;
        remDw <= loadLen;
        mpsQ  <= mpsSel;
        tagQ  <= reqTag;
        ridQ  <= reqRid;
        cidQ  <= cplId;
      end
      if (ctrl.hdrFire) begin
        beatsLeft <= chunk;
      end
      if (ctrl.beatFire) begin
        ptr       <= ptr + 1'b1;
        remDw     <= remDw - 1'b1;
        beatsLeft <= beatsLeft - 1'b1;
      end
    end
  end

  // look one address ahead on an accepted beat so the next word is ready
  assign memAddr = ctrl.beatFire ? ptr + 1'b1 : ptr;

  always_comb begin
    stat.lastBeat = (beatsLeft == REM_W'(1));
    stat.lastCpl  = (remDw == REM_W'(1));
  end

  assign cplLen     = chunk[LEN_W-1:0];
  assign cplByteCnt = {remDw[LEN_W-1:0], 2'b00};
  assign cplLowAddr = {ptr[4:0], 2'b00};
  assign cplTag     = tagQ;
  assign cplReqId   = ridQ;
  assign cplCplId   = cidQ;

endmodule

// File: rtl/cpl_splitter.sv
module cpl_splitter
  import cpl_splitter_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int LEN_W  = 10,
  parameter int TAG_W  = 8,
  parameter int ID_W   = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [ID_W-1:0]   reqRid,
  input  logic [2:0]        mpsSel,
  input  logic [ID_W-1:0]   cplId,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              outValid,
  input  logic              outReady,
  output logic              outSop,
  output logic              outEop,
  output logic [DATA_W-1:0] outData,
  output logic [LEN_W-1:0]  cplLen,
  output logic [LEN_W+1:0]  cplByteCnt,
  output logic [6:0]        cplLowAddr,
  output logic [TAG_W-1:0]  cplTag,
  output logic [ID_W-1:0]   cplReqId,
  output logic [ID_W-1:0]   cplCplId
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  cpl_splitter_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .outReady (outReady),
    .stat     (stat),
    .reqReady (reqReady),
    .outValid (outValid),
    .outSop   (outSop),
    .outEop   (outEop),
    .memRdEn  (memRdEn),
    .ctrl     (ctrl)
  );

  cpl_splitter_dp #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .TAG_W  (TAG_W),
    .ID_W   (ID_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqTag     (reqTag),
    .reqRid     (reqRid),
    .mpsSel     (mpsSel),
    .cplId      (cplId),
    .stat       (stat),
    .memAddr    (memAddr),
    .cplLen     (cplLen),
    .cplByteCnt (cplByteCnt),
    .cplLowAddr (cplLowAddr),
    .cplTag     (cplTag),
    .cplReqId   (cplReqId),
    .cplCplId   (cplCplId)
  );

  assign outData = outSop ? '0 : memRdData;

endmodule

// File: rtl/cpl_splitter_chk.sv
module cpl_splitter_chk
  import cpl_splitter_pkg::*;
#(
  parameter int LEN_W = 10,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [LEN_W-1:0] reqLen,
  input logic [TAG_W-1:0] reqTag,
  input logic [2:0]       mpsSel,
  input logic             outValid,
  input logic             outReady,
  input logic             outSop,
  input logic             outEop,
  input logic [LEN_W-1:0] cplLen,
  input logic [LEN_W+1:0] cplByteCnt,
  input logic [TAG_W-1:0] cplTag
);

  logic             accept;
  logic             hdrFire;
  logic             dataFire;
  logic [TAG_W-1:0] capTag;
  logic [7:0]       capMps;
  logic [LEN_W:0]   expRem;
  logic [LEN_W:0]   beatCnt;
  logic [LEN_W-1:0] curLen;
  logic [LEN_W+1:0] expBytes;

  assign accept   = reqValid && reqReady;
  assign hdrFire  = outValid && outReady && outSop;
  assign dataFire = outValid && outReady && !outSop;
  assign expBytes = {expRem[LEN_W-1:0], 2'b00};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capTag  <= '0;
      capMps  <= 8'd32;
      expRem  <= '0;
      beatCnt <= '0;
      curLen  <= '0;
    end else begin
      if (accept) begin
        capTag <= reqTag;
        capMps <= mpsDwords(mpsSel);
        expRem <= (reqLen == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, reqLen};
      end
      if (hdrFire) begin
        curLen  <= cplLen;
        beatCnt <= '0;
      end
      if (dataFire) begin
        expRem  <= expRem - 1'b1;
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

  // R3: header length within the limit latched at accept
  assert_len_limit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSop) |-> (cplLen != '0) && ({2'b00, cplLen} <= {{(LEN_W-6){1'b0}}, capMps}));

  // R4: tag repeated on every header
  assert_tag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSop) |-> (cplTag == capTag));

  // R5: byte count tracks remaining DWORDs
  assert_bytecnt_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSop) |-> (cplByteCnt == expBytes));

  // R8: header fields held under backpressure
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outSop) && $stable(cplLen) && $stable(cplByteCnt));

  // R9: request port closed while DWORDs are owed
  assert_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (expRem != '0) |-> !reqReady);

  // R9: port reopens after the final beat
  assert_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dataFire && outEop && expRem == 1) |=> reqReady);

  // R11: end of packet exactly at the announced length
  assert_eop_R11: assert property (@(posedge clk) disable iff (!rstN)
    dataFire |-> (outEop == ((beatCnt + 1'b1) == {1'b0, curLen})));

endmodule

bind cpl_splitter cpl_splitter_chk #(.LEN_W(LEN_W), .TAG_W(TAG_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqLen     (reqLen),
  .reqTag     (reqTag),
  .mpsSel     (mpsSel),
  .outValid   (outValid),
  .outReady   (outReady),
  .outSop     (outSop),
  .outEop     (outEop),
  .cplLen     (cplLen),
  .cplByteCnt (cplByteCnt),
  .cplTag     (cplTag)
);

// File: tb/sim_cpl_splitter.sv
`timescale 1ns/1ps
module sim_cpl_splitter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic [29:0] reqAddr;
  logic [9:0]  reqLen;
  logic [7:0]  reqTag;
  logic [15:0] reqRid;
  logic [2:0]  mpsSel;
  logic [15:0] cplId;
  logic        memRdEn;
  logic [29:0] memAddr;
  logic [31:0] memRdData;
  logic        outValid;
  logic        outReady;
  logic        outSop;
  logic        outEop;
  logic [31:0] outData;
  logic [9:0]  cplLen;
  logic [11:0] cplByteCnt;
  logic [6:0]  cplLowAddr;
  logic [7:0]  cplTag;
  logic [15:0] cplReqId;
  logic [15:0] cplCplId;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpl_splitter u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqTag(reqTag), .reqRid(reqRid),
    .mpsSel(mpsSel), .cplId(cplId), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .outValid(outValid), .outReady(outReady),
    .outSop(outSop), .outEop(outEop), .outData(outData), .cplLen(cplLen),
    .cplByteCnt(cplByteCnt), .cplLowAddr(cplLowAddr), .cplTag(cplTag),
    .cplReqId(cplReqId), .cplCplId(cplCplId)
  );

  function automatic logic [31:0] memFn(input logic [29:0] a);
    return ({2'b00, a} * 32'h9E3779B1) ^ 32'h5A0FC3A5;
  endfunction

  // synchronous memory model, one cycle latency
  always @(posedge clk) begin
    if (memRdEn) memRdData <= memFn(memAddr);
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mpsLimit(input logic [2:0] s);
    return (s < 3'd3) ? (32 << s) : 32;
  endfunction

  task automatic doReq(input logic [29:0] a, input logic [9:0] l, input logic [7:0] t,
                       input logic [15:0] r, input logic [2:0] ms, input logic [15:0] cid,
                       input bit stall, input int expCpls);
    int remDw = (l == 10'd0) ? 1024 : int'(l);
    int lim = mpsLimit(ms);
    logic [29:0] ptr = a;
    int beatsLeft = 0;
    bit wantHdr = 1'b1;
    int cpls = 0;
    bit done = 1'b0;
    bit first = 1'b1;
    bit prevStall = 1'b0;
    logic sSop;
    logic [31:0] sData;
    logic [9:0] sLen;
    logic [11:0] sBc;
    bit rdy;
    int want;

    @(negedge clk);
    reqAddr = a; reqLen = l; reqTag = t; reqRid = r; mpsSel = ms; cplId = cid;
    reqValid = 1'b1;
    chk(reqReady == 1'b1, "R9 ready when idle", 32'(reqReady), 32'd1);
    @(negedge clk);
    // a second request and changed settings while busy
    reqAddr = ~a; reqLen = 10'd7; reqTag = ~t; reqRid = ~r; mpsSel = 3'd2; cplId = ~cid;
    chk(reqReady == 1'b0, "R9 busy after accept", 32'(reqReady), 32'd0);
    while (!done) begin
      if (!first) reqValid = 1'b0;
      first = 1'b0;
      if (prevStall) begin
        chk(outSop == sSop && outData == sData && cplLen == sLen && cplByteCnt == sBc,
            "R8 hold under stall", {outSop, outData[30:0]}, {sSop, sData[30:0]});
      end
      if (!outValid) begin
        chk(1'b0, "R11 valid during transfer", 32'(outValid), 32'd1);
        done = 1'b1;
      end else begin
        rdy = stall ? ($urandom_range(0, 3) != 0) : 1'b1;
        outReady = rdy;
        if (rdy) begin
          prevStall = 1'b0;
          if (wantHdr) begin
            want = (remDw < lim) ? remDw : lim;
            chk(outSop == 1'b1, "R11 header sop", 32'(outSop), 32'd1);
            chk(int'(cplLen) == want, "R3 completion length", 32'(cplLen), 32'(want));
            chk(cplByteCnt == 12'(remDw * 4), "R5 byte count", 32'(cplByteCnt), 32'(12'(remDw * 4)));
            chk(cplLowAddr == {ptr[4:0], 2'b00}, "R6 lower address", 32'(cplLowAddr), 32'({ptr[4:0], 2'b00}));
            chk(cplTag == t && cplReqId == r, "R4 tag and requester", {cplTag, cplReqId}, {t, r});
            chk(cplCplId == cid, "R10 completer id latched", 32'(cplCplId), 32'(cid));
            beatsLeft = want;
            wantHdr = 1'b0;
            cpls++;
          end else begin
            chk(outSop == 1'b0, "R11 data beat sop", 32'(outSop), 32'd0);
            chk(outData == memFn(ptr), "R7 payload word", outData, memFn(ptr));
            chk(outEop == (beatsLeft == 1), "R11 eop position", 32'(outEop), 32'(beatsLeft == 1));
            ptr = ptr + 30'd1;
            remDw--;
            beatsLeft--;
            if (beatsLeft == 0) wantHdr = 1'b1;
            if (remDw == 0) done = 1'b1;
          end
        end else begin
          prevStall = 1'b1;
          sSop = outSop; sData = outData; sLen = cplLen; sBc = cplByteCnt;
        end
      end
      @(negedge clk);
    end
    outReady = 1'b0;
    chk(outValid == 1'b0 && reqReady == 1'b1, "R9 idle after final beat",
        {outValid, reqReady}, 32'd1);
    if (expCpls >= 0) chk(cpls == expCpls, "R3 completion count", 32'(cpls), 32'(expCpls));
  endtask

  // gap-free streaming: count cycles of a request with ready high throughout
  task automatic gapCheck;
    int cyc = 0;
    @(negedge clk);
    reqAddr = 30'h100; reqLen = 10'd64; reqTag = 8'h11; reqRid = 16'h0200;
    mpsSel = 3'd0; cplId = 16'h0008; reqValid = 1'b1; outReady = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (outValid && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
    // 2 headers + 64 data beats
    chk(cyc == 66, "R12 one beat per cycle", 32'(cyc), 32'd66);
    outReady = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqLen = '0; reqTag = '0;
    reqRid = '0; mpsSel = '0; cplId = '0; outReady = 1'b0;
    repeat (3) @(negedge clk);
    chk(outValid == 1'b0 && reqReady == 1'b1, "R1 state in reset", {outValid, reqReady}, 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 1'b0 && reqReady == 1'b1, "R1 state after reset", {outValid, reqReady}, 32'd1);

    // R2 and R3: maximum length read under each payload code
    doReq(30'h400, 10'd0, 8'h80, 16'h2A00, 3'd0, 16'h000B, 1'b0, 32);
    doReq(30'h400, 10'd0, 8'h81, 16'h2A00, 3'd1, 16'h000B, 1'b1, 16);
    doReq(30'h1234, 10'd0, 8'h82, 16'h2A00, 3'd2, 16'h0100, 1'b1, 8);
    // reserved code falls back to 32 DWORDs
    doReq(30'h55, 10'd100, 8'h23, 16'h0000, 3'd5, 16'h1A00, 1'b1, 4);
    // single DWORD, remainder completion, odd lower address
    doReq(30'h3, 10'd1, 8'h01, 16'hBEEF, 3'd0, 16'h0001, 1'b0, 1);
    doReq(30'h1F, 10'd33, 8'h02, 16'h0102, 3'd0, 16'h0002, 1'b1, 2);
    // address wraparound
    doReq(30'h3FFFFFF0, 10'd40, 8'h03, 16'h0303, 3'd1, 16'h0003, 1'b1, 1);
    gapCheck();
    for (int i = 0; i < 20; i++) begin
      doReq(30'($urandom), 10'($urandom_range(1, 300)), 8'($urandom), 16'($urandom),
            3'($urandom_range(0, 7)), 16'($urandom), 1'($urandom_range(0, 1)), -1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule